// File: doc/BRIEF.md
# Calibration Overlay Address Remapper

This block sits in front of a flash array and redirects selected read addresses into a separate overlay memory, so that calibration tables can be tuned at run time without reprogramming flash. Software programs a small bank of region descriptors. Each descriptor holds a logical base address, a physical destination base and a power-of-two size code. A separate enable register holds one valid bit per descriptor.

Every access address is compared in parallel against all valid descriptors. Regions are naturally aligned, so a hit is decided by masking off the offset bits below the region size and comparing what remains with the logical base. On a hit the block replaces the upper address bits with the physical base and keeps the offset. On a miss the address passes through unchanged. The result is produced combinationally, and a copy registered on the next clock edge is also provided. Any write to a descriptor's address or size word drops that descriptor's valid bit, so a half-edited region can never remap. Register access is allowed in supervisor mode only.

Top module: `cal_overlay_remap`

## Requirements
- R1: After reset every descriptor word and the enable register read as zero, and no address is remapped.
- R2: The enable register sits at byte offset 0x0F0, with bit n the valid bit of descriptor n. Descriptor n occupies offsets 0x100+16*n (logical base), +4 (physical base) and +8 (size code). Read data and the error flag appear on the clock edge that follows the access.
- R3: The logical and physical base words keep only bits 31:4, and bits 3:0 read as zero. The size word keeps only bits 4:0, and its other bits read as zero.
- R4: Offset +12 of each slot, and any offset that is neither the enable register nor a descriptor word, reads as zero and ignores writes. A write there leaves every enable bit unchanged.
- R5: A supervisor write to the logical base, physical base or size word of descriptor n clears enable bit n and leaves the other enable bits as they were.
- R6: Descriptor n, with size 2^k, hits when its enable bit is set and (addr & ~(2^k-1)) equals its logical base. Then map_hit is 1 and map_addr = physical base | (addr & (2^k-1)).
- R7: A size code below 4 behaves as 4 and a size code above 20 behaves as 20.
- R8: When no descriptor hits, map_hit is 0 and map_addr equals acc_addr.
- R9: When several descriptors hit, the lowest-numbered one supplies map_addr and map_idx. On a miss map_idx is 0.
- R10: map_addr_q and map_hit_q hold, after each rising clock edge, the map_addr and map_hit values present before that edge.
- R11: An access with reg_super low reads zero and changes no register. It raises reg_err for exactly the following cycle. A supervisor access leaves reg_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_super | input | 1 | Access is made in supervisor mode |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| reg_err | output | 1 | One-cycle pulse after a non-supervisor access |
| acc_addr | input | 32 | Logical access address |
| map_addr | output | 32 | Remapped or passed-through address |
| map_hit | output | 1 | A descriptor matched |
| map_idx | output | 2 | Index of the matching descriptor |
| map_addr_q | output | 32 | map_addr registered |
| map_hit_q | output | 1 | map_hit registered |

## Verification
The bench builds the block with its default parameters: four descriptors and a size range of 2^4 to 2^20 bytes. Four descriptors are enough to let regions of different sizes overlap, so priority can be tested both when the lower and when only the higher descriptor matches. The top slot lies next to the end of the descriptor window, so the unmapped offset just past it can be tested. Size codes of 2 and 31 test both ends of the clamp, using offsets just inside and just outside the clamped region.

// File: rtl/cor_pkg.sv
package cor_pkg;

  localparam int unsigned DW  = 32;
  localparam int unsigned KW  = 5;
  localparam int unsigned RAW = 12;

  typedef struct packed {
    logic [DW-1:0] lbase;
    logic [DW-1:0] pbase;
    logic [KW-1:0] kcode;
  } cor_desc_t;

  function automatic logic [KW-1:0] cor_clamp(input logic [KW-1:0] k,
                                               input logic [KW-1:0] kmin,
                                               input logic [KW-1:0] kmax);
    if (k < kmin)      return kmin;
    else if (k > kmax) return kmax;
    else               return k;
  endfunction

endpackage

// File: rtl/cor_regs.sv
module cor_regs
  import cor_pkg::*;
#(
  parameter int unsigned NUM_DESC = 4,
  localparam int unsigned IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            we_i,
  input  logic            super_i,
  input  logic [RAW-1:0]  addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            err_o,
  output cor_desc_t       desc_o [NUM_DESC],
  output logic [NUM_DESC-1:0] en_o
);

  localparam logic [RAW-1:0] EN_OFS   = 12'h0F0;
  localparam logic [RAW-1:0] SLOT_LO  = 12'h100;
  localparam logic [RAW-1:0] SLOT_HI  = RAW'(32'h100 + 16 * NUM_DESC);

  cor_desc_t            desc_q [NUM_DESC];
  cor_desc_t            desc_d [NUM_DESC];
  logic [NUM_DESC-1:0]  en_q, en_d;
  logic [DW-1:0]        rdata_q, rdata_d;
  logic                 err_q, err_d;

  logic                 hit_en, hit_slot, wr_ok, rd_ok, upd;
  logic [IDX_W-1:0]     slot;
  logic [1:0]           word;

  assign hit_en   = (addr_i == EN_OFS);
  assign hit_slot = (addr_i >= SLOT_LO) && (addr_i < SLOT_HI) && (addr_i[1:0] == 2'b00);
  assign slot     = addr_i[4 +: IDX_W];
  assign word     = addr_i[3:2];
  assign wr_ok    = sel_i && we_i && super_i;
  assign rd_ok    = sel_i && !we_i && super_i;
  assign upd      = wr_ok && (hit_en || (hit_slot && (word != 2'd3)));

  always_comb begin
    desc_d = desc_q;
    en_d   = en_q;
    if (wr_ok) begin
      if (hit_en) begin
        en_d = wdata_i[NUM_DESC-1:0];
      end else if (hit_slot) begin
        case (word)
          2'd0:    desc_d[slot].lbase = {wdata_i[DW-1:4], 4'b0000};
          2'd1:    desc_d[slot].pbase = {wdata_i[DW-1:4], 4'b0000};
          2'd2:    desc_d[slot].kcode = wdata_i[KW-1:0];
          default: ;
        endcase
        if (word != 2'd3) en_d[slot] = 1'b0;
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (rd_ok) begin
      if (hit_en) begin
        rdata_d[NUM_DESC-1:0] = en_q;
      end else if (hit_slot) begin
        case (word)
          2'd0:    rdata_d = desc_q[slot].lbase;
          2'd1:    rdata_d = desc_q[slot].pbase;
          2'd2:    rdata_d[KW-1:0] = desc_q[slot].kcode;
          default: rdata_d = '0;
        endcase
      end
    end
    err_d = sel_i && !super_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DESC; i++) desc_q[i] <= '0;
      en_q <= '0;
    end else if (upd) begin
      desc_q <= desc_d;
      en_q   <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      err_q   <= err_d;
    end
  end

  assign desc_o  = desc_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;

  // R11
  user_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !super_i) |=> err_o);
  // R11
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_i && !super_i) |=> !err_o);
  // R11
  user_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && we_i && !super_i) |=> $stable(en_o));
  // R4
  pad_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && hit_slot && (word == 2'd3)) |=> $stable(en_o));

  for (genvar n = 0; n < NUM_DESC; n++) begin : g_inv
    // R5
    inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && hit_slot && (slot == IDX_W'(n)) && (word != 2'd3)) |=> !en_o[n]);
  end

endmodule

// File: rtl/cor_hit.sv
module cor_hit
  import cor_pkg::*;
#(
  parameter int unsigned K_MIN = 4,
  parameter int unsigned K_MAX = 20
) (
  input  cor_desc_t      desc_i,
  input  logic           en_i,
  input  logic [DW-1:0]  addr_i,
  output logic           hit_o,
  output logic [DW-1:0]  paddr_o
);

  logic [KW-1:0] k_eff;
  logic [DW-1:0] lo_mask;

  always_comb begin
    k_eff   = cor_clamp(desc_i.kcode, KW'(K_MIN), KW'(K_MAX));
    lo_mask = (DW'(1) << k_eff) - DW'(1);
    hit_o   = en_i && ((addr_i & ~lo_mask) == desc_i.lbase);
    paddr_o = desc_i.pbase | (addr_i & lo_mask);
  end

endmodule

// File: rtl/cor_pick.sv
module cor_pick
  import cor_pkg::*;
#(
  parameter int unsigned NUM_DESC = 4,
  localparam int unsigned IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_DESC-1:0] hits_i,
  input  logic [DW-1:0]       paddr_i [NUM_DESC],
  input  logic [DW-1:0]       addr_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [DW-1:0]       addr_o
);

  always_comb begin
    hit_o  = 1'b0;
    idx_o  = '0;
    addr_o = addr_i;
    for (int i = NUM_DESC - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        hit_o  = 1'b1;
        idx_o  = IDX_W'(i);
        addr_o = paddr_i[i];
      end
    end
  end

  // R9
  lowest_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (hits_i[idx_o] && ((hits_i & ((NUM_DESC'(1) << idx_o) - NUM_DESC'(1))) == '0)));
  // R8
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hits_i == '0) |-> (!hit_o && (addr_o == addr_i)));

endmodule

// File: rtl/cal_overlay_remap.sv
module cal_overlay_remap
  import cor_pkg::*;
#(
  parameter int unsigned NUM_DESC = 4,
  parameter int unsigned K_MIN    = 4,
  parameter int unsigned K_MAX    = 20,
  localparam int unsigned IDX_W   = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_we,
  input  logic             reg_super,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             reg_err,
  input  logic [31:0]      acc_addr,
  output logic [31:0]      map_addr,
  output logic             map_hit,
  output logic [IDX_W-1:0] map_idx,
  output logic [31:0]      map_addr_q,
  output logic             map_hit_q
);

  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  cor_desc_t           desc [NUM_DESC];
  logic [NUM_DESC-1:0] en;
  logic [NUM_DESC-1:0] hits;
  logic [DW-1:0]       paddr [NUM_DESC];

  cor_regs #(.NUM_DESC(NUM_DESC)) u_regs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .sel_i  (reg_sel),
    .we_i   (reg_we),
    .super_i(reg_super),
    .addr_i (reg_addr),
    .wdata_i(reg_wdata),
    .rdata_o(reg_rdata),
    .err_o  (reg_err),
    .desc_o (desc),
    .en_o   (en)
  );

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_hit
    cor_hit #(.K_MIN(K_MIN), .K_MAX(K_MAX)) u_hit (
      .desc_i (desc[g]),
      .en_i   (en[g]),
      .addr_i (acc_addr),
      .hit_o  (hits[g]),
      .paddr_o(paddr[g])
    );
  end

  cor_pick #(.NUM_DESC(NUM_DESC)) u_pick (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .hits_i (hits),
    .paddr_i(paddr),
    .addr_i (acc_addr),
    .hit_o  (map_hit),
    .idx_o  (map_idx),
    .addr_o (map_addr)
  );

  logic [DW-1:0] maq_d;
  logic          mhq_d;

  always_comb begin
    maq_d = map_addr;
    mhq_d = map_hit;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      map_addr_q <= '0;
      map_hit_q  <= 1'b0;
    end else begin
      map_addr_q <= maq_d;
      map_hit_q  <= mhq_d;
    end
  end

  // R10
  reg_stage_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ##1 (map_hit_q == $past(map_hit)) && (map_addr_q == $past(map_addr)));

endmodule

// File: tb/cal_overlay_remap_bench.sv
module cal_overlay_remap_bench;

  localparam int ND = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0, reg_super = 1'b1;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_err;
  logic [31:0] acc_addr = '0;
  logic [31:0] map_addr, map_addr_q;
  logic        map_hit, map_hit_q;
  logic [1:0]  map_idx;

  always #5 clk = ~clk;

  cal_overlay_remap u_cal_overlay_remap (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_super(reg_super), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_err(reg_err), .acc_addr(acc_addr),
    .map_addr(map_addr), .map_hit(map_hit), .map_idx(map_idx),
    .map_addr_q(map_addr_q), .map_hit_q(map_hit_q)
  );

  typedef enum int {S_RD, S_ERR, S_MA, S_MH, S_MI, S_QA, S_QH} sig_e;
  typedef struct {
    int          due;
    sig_e        sig;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sbq[$];
  int cyc = 0, nchk = 0, nfail = 0;
  bit done = 0;

  logic [31:0] m_l [ND];
  logic [31:0] m_p [ND];
  logic [4:0]  m_k [ND];
  logic [ND-1:0] m_en;

  task automatic push(input int due, input sig_e s, input logic [31:0] e, input string tag);
    item_t it;
    it.due = due; it.sig = s; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  function automatic logic [31:0] observe(input sig_e s);
    case (s)
      S_RD:  return reg_rdata;
      S_ERR: return {31'b0, reg_err};
      S_MA:  return map_addr;
      S_MH:  return {31'b0, map_hit};
      S_MI:  return {30'b0, map_idx};
      S_QA:  return map_addr_q;
      default: return {31'b0, map_hit_q};
    endcase
  endfunction

  // monitor: pops expected items when due and compares
  always @(negedge clk) begin
    cyc = cyc + 1;
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = sbq.pop_front();
      act = observe(it.sig);
      nchk++;
      if (act !== it.exp) begin
        nfail++;
        $display("FAIL %s sig=%s actual=%08h expected=%08h", it.tag, it.sig.name(), act, it.exp);
      end
    end
  end

  function automatic int kclamp(input logic [4:0] k);
    if (k < 5'd4) return 4;
    if (k > 5'd20) return 20;
    return int'(k);
  endfunction

  function automatic bit is_slot(input logic [11:0] a);
    return (a >= 12'h100) && (a < 12'h140) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a, input logic sup);
    if (!sup) return 32'h0;
    if (a == 12'h0F0) return {28'b0, m_en};
    if (is_slot(a)) begin
      case (a[3:2])
        2'd0: return m_l[a[5:4]];
        2'd1: return m_p[a[5:4]];
        2'd2: return {27'b0, m_k[a[5:4]]};
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic sup);
    if (!sup) return;
    if (a == 12'h0F0) m_en = d[ND-1:0];
    else if (is_slot(a) && a[3:2] != 2'd3) begin
      case (a[3:2])
        2'd0: m_l[a[5:4]] = {d[31:4], 4'b0};
        2'd1: m_p[a[5:4]] = {d[31:4], 4'b0};
        default: m_k[a[5:4]] = d[4:0];
      endcase
      m_en[a[5:4]] = 1'b0;
    end
  endtask

  task automatic model_map(input logic [31:0] a, output logic h, output logic [1:0] ix,
                           output logic [31:0] pa);
    h = 0; ix = 0; pa = a;
    for (int i = ND - 1; i >= 0; i--) begin
      logic [31:0] m;
      m = (32'h1 << kclamp(m_k[i])) - 32'h1;
      if (m_en[i] && ((a & ~m) == m_l[i])) begin
        h = 1; ix = 2'(i); pa = m_p[i] | (a & m);
      end
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d, input logic sup,
                        input string tag);
    @(negedge clk); #1;
    reg_sel = 1; reg_we = 1; reg_super = sup; reg_addr = a; reg_wdata = d;
    push(cyc + 1, S_ERR, {31'b0, ~sup}, tag);
    model_write(a, d, sup);
    @(negedge clk); #1;
    reg_sel = 0; reg_we = 0; reg_super = 1;
  endtask

  task automatic reg_rd(input logic [11:0] a, input logic sup, input string tag);
    @(negedge clk); #1;
    reg_sel = 1; reg_we = 0; reg_super = sup; reg_addr = a;
    push(cyc + 1, S_RD, model_read(a, sup), tag);
    push(cyc + 1, S_ERR, {31'b0, ~sup}, tag);
    @(negedge clk); #1;
    reg_sel = 0; reg_super = 1;
  endtask

  task automatic map_chk(input logic [31:0] a, input string tag);
    logic h; logic [1:0] ix; logic [31:0] pa;
    @(negedge clk); #1;
    acc_addr = a;
    model_map(a, h, ix, pa);
    push(cyc + 1, S_MH, {31'b0, h}, tag);
    push(cyc + 1, S_MA, pa, tag);
    push(cyc + 1, S_MI, {30'b0, ix}, tag);
    push(cyc + 1, S_QH, {31'b0, h}, {tag, " R10"});
    push(cyc + 1, S_QA, pa, {tag, " R10"});
    @(negedge clk); #1;
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin m_l[i] = 0; m_p[i] = 0; m_k[i] = 0; end
    m_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    reg_rd(12'h0F0, 1, "R1 enable after reset");
    reg_rd(12'h120, 1, "R1 slot2 word0 after reset");
    reg_rd(12'h128, 1, "R1 slot2 size after reset");
    map_chk(32'h1234_5678, "R1 R8 no remap after reset");

    // R2 R3 field layout
    reg_wr(12'h100, 32'h0004_0007, 1, "R2 write slot0 lbase");
    reg_rd(12'h100, 1, "R3 lbase low bits zero");
    reg_wr(12'h104, 32'h2000_000F, 1, "R2 write slot0 pbase");
    reg_rd(12'h104, 1, "R3 pbase low bits zero");
    reg_wr(12'h108, 32'hFFFF_FFEC, 1, "R2 write slot0 size");
    reg_rd(12'h108, 1, "R3 size keeps bits 4:0");
    reg_wr(12'h0F0, 32'h0000_0001, 1, "R2 enable slot0");
    reg_rd(12'h0F0, 1, "R2 enable readback");

    // R6 R8 hit / miss
    map_chk(32'h0004_0ABC, "R6 hit slot0");
    map_chk(32'h0004_1000, "R8 just past region");
    map_chk(32'h0003_FFFF, "R8 just below region");

    // R5 invalidation
    reg_wr(12'h108, 32'h0000_000C, 1, "R5 rewrite slot0 size");
    reg_rd(12'h0F0, 1, "R5 slot0 invalid after write");
    map_chk(32'h0004_0ABC, "R5 no hit when invalid");
    reg_wr(12'h110, 32'h0004_0000, 1, "R5 slot1 lbase");
    reg_wr(12'h114, 32'h5000_0000, 1, "R5 slot1 pbase");
    reg_wr(12'h118, 32'h0000_0010, 1, "R5 slot1 size");
    reg_wr(12'h0F0, 32'h0000_0003, 1, "R5 enable 0 and 1");
    reg_wr(12'h114, 32'h5000_0000, 1, "R5 rewrite slot1 pbase");
    reg_rd(12'h0F0, 1, "R5 only bit1 cleared");
    reg_wr(12'h0F0, 32'h0000_0003, 1, "R9 enable 0 and 1");

    // R9 priority
    map_chk(32'h0004_0010, "R9 both hit lowest wins");
    map_chk(32'h0004_2000, "R9 only slot1 hits");

    // R7 clamp
    reg_wr(12'h120, 32'h0010_0000, 1, "R7 slot2 lbase");
    reg_wr(12'h124, 32'h3000_0000, 1, "R7 slot2 pbase");
    reg_wr(12'h128, 32'h0000_0002, 1, "R7 slot2 size 2");
    reg_wr(12'h130, 32'h0020_0000, 1, "R7 slot3 lbase");
    reg_wr(12'h134, 32'h4000_0000, 1, "R7 slot3 pbase");
    reg_wr(12'h138, 32'h0000_001F, 1, "R7 slot3 size 31");
    reg_wr(12'h0F0, 32'h0000_000F, 1, "R7 enable all");
    map_chk(32'h0010_000F, "R7 low clamp inside");
    map_chk(32'h0010_0010, "R7 low clamp outside");
    map_chk(32'h002F_FFFF, "R7 high clamp inside");
    map_chk(32'h0030_0000, "R7 high clamp outside");

    // R4 unused word and unmapped offsets
    reg_wr(12'h10C, 32'hFFFF_FFFF, 1, "R4 write pad word");
    reg_rd(12'h10C, 1, "R4 pad reads zero");
    reg_rd(12'h0F0, 1, "R4 enable unchanged by pad write");
    reg_wr(12'h140, 32'hFFFF_FFFF, 1, "R4 write past window");
    reg_rd(12'h140, 1, "R4 unmapped reads zero");
    reg_rd(12'h100, 1, "R4 slot0 untouched");

    // R11 non-supervisor
    reg_rd(12'h100, 0, "R11 user read zero and err");
    reg_wr(12'h0F0, 32'h0000_0000, 0, "R11 user write err");
    reg_rd(12'h0F0, 1, "R11 enable unchanged by user write");
    reg_wr(12'h104, 32'h7777_7770, 0, "R11 user write pbase");
    reg_rd(12'h104, 1, "R11 pbase unchanged");
    map_chk(32'h0004_0010, "R11 mapping unchanged");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

endmodule